// File: doc/BRIEF.md
# Block Address Translation Match Unit

This unit holds a small bank of block-translation entries, each made of an upper and a lower 32-bit register. Every entry describes one aligned region of effective address space. The region is between 128 KB and 256 MB in size, and a per-entry length mask sets that size. The unit maps the region onto a physical block and attaches cache attributes and a protection code to it.

An effective address and the current privilege and access type are presented on the lookup inputs. All entries are compared at once, with no clock on that path. The unit returns several things for the same cycle:

- whether any entry hit, and which entry it was;
- the translated physical address;
- the write-through, inhibit, coherent and guarded attributes of the winning entry;
- whether the access is allowed.

Software loads the registers one word at a time through a single synchronous write port. A parameter makes an instance either instruction-side or data-side. An instruction-side instance never holds a guarded attribute.

Top module: `blk_xlate_unit`

## Requirements
- R1: After a synchronous active-low reset, every register reads as zero. All entries are invalid, and `hit`, `access_ok` and all attribute outputs are 0 for any lookup.
- R2: When `wr_en` is 1 at a rising clock edge, `wr_data` is stored into entry `wr_idx`. It goes to the upper register when `wr_upper` is 1 and to the lower register when `wr_upper` is 0. The new contents govern lookups from the cycle after that edge.
- R3: The upper register has four fields. Bits [31:17] hold the effective block index. Bits [12:2] hold the 11-bit length mask. Bit 1 is supervisor-valid and bit 0 is user-valid. Effective address bits [31:17] are compared against the index. For each set bit k of the mask, address bit 17+k is left out of the compare. Mask 0x000 therefore gives a 128 KB block, and 0x7FF gives 256 MB.
- R4: An entry can match only if its valid bit for the current mode is 1. Supervisor-valid applies when `priv_super` is 1, and user-valid applies when `priv_super` is 0.
- R5: The lower register holds the physical block index in bits [31:17]. On a hit, `pa[16:0]` equals `ea[16:0]`. For each bit k of `pa[31:17]`, the value comes from the effective address when mask bit k is set, and from the physical block index otherwise. Mask bits above bit 10 are taken as zero.
- R6: When several entries match, the lowest-numbered one wins, and `hit_idx` gives its number.
- R7: The lower register has four attribute bits: bit 6 is write-through, bit 5 is inhibit, bit 4 is coherent and bit 3 is guarded. On a hit, the winning entry's attributes are driven out. On a miss, all attribute outputs are 0.
- R8: The protection field sits in lower bits [1:0]. Code 00 allows no access. Codes 01 and 11 allow reads only. Code 10 allows reads and writes. `access_ok` is 1 only on a hit whose protection code allows the access type given by `acc_write`.
- R9: In an instance with `INSTR_SIDE`=1, a lower-register write stores the guarded bit as 0, so `attr_g` is never 1. With `INSTR_SIDE`=0, the guarded bit is kept as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 2 | Entry selected for the write |
| wr_upper | input | 1 | 1 writes the upper register, 0 the lower |
| wr_data | input | 32 | Register write data |
| ea | input | 32 | Effective address to translate |
| priv_super | input | 1 | 1 for supervisor mode, 0 for user mode |
| acc_write | input | 1 | 1 for a store access, 0 for a load or fetch |
| hit | output | 1 | Some entry matched |
| hit_idx | output | 2 | Number of the winning entry |
| pa | output | 32 | Translated physical address |
| attr_w | output | 1 | Write-through attribute |
| attr_i | output | 1 | Cache-inhibit attribute |
| attr_m | output | 1 | Coherence attribute |
| attr_g | output | 1 | Guarded attribute |
| access_ok | output | 1 | Access allowed for this mode and access type |

## Verification
Each of the twelve block sizes is tried with addresses inside the block, with addresses that flip the highest masked bit (these must still hit), and with addresses that flip the lowest unmasked bit (these must miss). This separates an off-by-one in the mask span from a correct compare, and it shows that the pass-through bits come from the address and the rest from the physical index. Overlapping entries are switched off one at a time to expose the priority order. Every protection code is crossed with both modes and both access types to tell the read-only and no-access cases apart. A long pseudo-random sweep then reprograms the registers with mixed valid bits and masks, and checks both an instruction-side and a data-side instance against an arithmetic model.

// File: rtl/blk_xlate_pkg.sv
// Shared widths, register field layouts and protection codes for the
// block address translation unit. Assumes a 32-bit effective address.
package blk_xlate_pkg;
    localparam int EA_W  = 32;
    localparam int IDX_W = 15;
    localparam int LEN_W = 11;
    localparam int OFS_W = EA_W - IDX_W;

    localparam logic [1:0] PROT_NONE = 2'b00;
    localparam logic [1:0] PROT_RO   = 2'b01;
    localparam logic [1:0] PROT_RW   = 2'b10;

    typedef struct packed {
        logic [IDX_W-1:0] epi;
        logic [LEN_W-1:0] len;
        logic             sv;
        logic             uv;
    } upper_t;

    typedef struct packed {
        logic [IDX_W-1:0] ppi;
        logic             w;
        logic             i;
        logic             m;
        logic             g;
        logic [1:0]       prot;
    } lower_t;

    function automatic upper_t unpack_upper(input logic [EA_W-1:0] d);
        upper_t u;
        u.epi = d[EA_W-1:OFS_W];
        u.len = d[LEN_W+1:2];
        u.sv  = d[1];
        u.uv  = d[0];
        return u;
    endfunction

    function automatic lower_t unpack_lower(input logic [EA_W-1:0] d);
        lower_t l;
        l.ppi  = d[EA_W-1:OFS_W];
        l.w    = d[6];
        l.i    = d[5];
        l.m    = d[4];
        l.g    = d[3];
        l.prot = d[1:0];
        return l;
    endfunction
endpackage

// File: rtl/blk_xlate_entry.sv
// One translation entry: an upper/lower register pair plus its compare and
// physical index formation. Assumes the write enables are already decoded
// per entry. The compare is purely combinational on the lookup inputs.
module blk_xlate_entry
    import blk_xlate_pkg::*;
#(
    parameter bit INSTR_SIDE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hi_en,
    input  logic             wr_lo_en,
    input  logic [EA_W-1:0]  wr_data,
    input  logic [EA_W-1:0]  ea,
    input  logic             priv_super,
    output logic             match,
    output logic [IDX_W-1:0] pa_idx,
    output lower_t           lo
);
    upper_t           up_q;
    lower_t           lo_q;
    lower_t           lo_in;
    logic [IDX_W-1:0] keep;
    logic [IDX_W-1:0] ea_idx;

    // Form the lower word to store, clearing guarded on the instruction side.
    always_comb begin
        lo_in = unpack_lower(wr_data);
        if (INSTR_SIDE) lo_in.g = 1'b0;
    end

    // Register pair with synchronous reset and independent word writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q <= '0;
            lo_q <= '0;
        end else begin
            if (wr_hi_en) up_q <= unpack_upper(wr_data);
            if (wr_lo_en) lo_q <= lo_in;
        end
    end

    // Masked block compare, mode gating and physical index pass-through.
    always_comb begin
        ea_idx = ea[EA_W-1:OFS_W];
        keep   = ~{{(IDX_W-LEN_W){1'b0}}, up_q.len};
        match  = (((ea_idx ^ up_q.epi) & keep) == '0) &&
                 (priv_super ? up_q.sv : up_q.uv);
        pa_idx = (lo_q.ppi & keep) | (ea_idx & ~keep);
    end

    assign lo = lo_q;

    // R2
    upper_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi_en |=> (up_q.epi == $past(wr_data[EA_W-1:OFS_W])));

    generate
        if (INSTR_SIDE) begin : g_instr
            // R9
            guard_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wr_lo_en |=> !lo_q.g);
        end
    endgenerate
endmodule

// File: rtl/blk_xlate_prio.sv
// Fixed-priority selector: the lowest-numbered asserted match wins.
// Assumes N_ENTRIES is at least 2.
module blk_xlate_prio #(
    parameter int N_ENTRIES = 4,
    localparam int SEL_W    = $clog2(N_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_ENTRIES-1:0] match,
    output logic                 any,
    output logic [SEL_W-1:0]     sel,
    output logic [N_ENTRIES-1:0] grant
);
    // Scan from the top so that the lowest index is assigned last.
    always_comb begin
        sel   = '0;
        grant = '0;
        for (int k = N_ENTRIES - 1; k >= 0; k--) begin
            if (match[k]) begin
                sel   = SEL_W'(k);
                grant = N_ENTRIES'(1) << k;
            end
        end
        any = |match;
    end

    // R6
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (any == (grant != '0)));
    // R6
    sel_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (match[sel] && ((match & ((N_ENTRIES'(1) << sel) - 1'b1)) == '0)));
endmodule

// File: rtl/blk_xlate_unit.sv
// Block address translation unit: a bank of entries, a fixed-priority
// select, and the output mux with the protection check. Assumes lookups
// are combinational and that writes take effect after the clock edge.
module blk_xlate_unit
    import blk_xlate_pkg::*;
#(
    parameter int N_ENTRIES  = 4,
    parameter bit INSTR_SIDE = 1'b0,
    localparam int SEL_W     = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_idx,
    input  logic             wr_upper,
    input  logic [EA_W-1:0]  wr_data,
    input  logic [EA_W-1:0]  ea,
    input  logic             priv_super,
    input  logic             acc_write,
    output logic             hit,
    output logic [SEL_W-1:0] hit_idx,
    output logic [EA_W-1:0]  pa,
    output logic             attr_w,
    output logic             attr_i,
    output logic             attr_m,
    output logic             attr_g,
    output logic             access_ok
);
    logic [N_ENTRIES-1:0] match;
    logic [N_ENTRIES-1:0] grant;
    logic [IDX_W-1:0]     pa_idx [N_ENTRIES];
    lower_t               lo     [N_ENTRIES];
    lower_t               sel_lo;
    logic                 any;
    logic [SEL_W-1:0]     sel;

    generate
        for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
            blk_xlate_entry #(.INSTR_SIDE(INSTR_SIDE)) u_ent (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_hi_en   (wr_en && wr_upper && (wr_idx == SEL_W'(e))),
                .wr_lo_en   (wr_en && !wr_upper && (wr_idx == SEL_W'(e))),
                .wr_data    (wr_data),
                .ea         (ea),
                .priv_super (priv_super),
                .match      (match[e]),
                .pa_idx     (pa_idx[e]),
                .lo         (lo[e])
            );
        end
    endgenerate

    blk_xlate_prio #(.N_ENTRIES(N_ENTRIES)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .match (match),
        .any   (any),
        .sel   (sel),
        .grant (grant)
    );

    // Drive the winning entry's translation, attributes and permission.
    always_comb begin
        sel_lo    = any ? lo[sel] : '0;
        hit       = any;
        hit_idx   = sel;
        pa        = any ? {pa_idx[sel], ea[OFS_W-1:0]} : '0;
        attr_w    = sel_lo.w;
        attr_i    = sel_lo.i;
        attr_m    = sel_lo.m;
        attr_g    = sel_lo.g;
        unique case (sel_lo.prot)
            PROT_NONE: access_ok = 1'b0;
            PROT_RW:   access_ok = any;
            default:   access_ok = any && !acc_write;
        endcase
    end

    // R5
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (pa[OFS_W-1:0] == ea[OFS_W-1:0]));
    // R8
    ok_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        access_ok |-> hit);
    // R8
    write_needs_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (access_ok && acc_write) |-> (sel_lo.prot == PROT_RW));
    // R7
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> !(attr_w || attr_i || attr_m || attr_g));
endmodule

// File: tb/tb_blk_xlate_unit.sv
module tb_blk_xlate_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic        wr_upper = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] ea = '0;
    logic        priv_super = 1'b0;
    logic        acc_write = 1'b0;

    logic        hit_i, hit_d, w_i, w_d, c_i, c_d, m_i, m_d, g_i, g_d, ok_i, ok_d;
    logic [1:0]  idx_i, idx_d;
    logic [31:0] pa_i, pa_d;

    logic [31:0] up_sh [4];
    logic [31:0] lo_sh [4];
    int          n_vec = 0;
    int          n_bad = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #2 clk = ~clk;

    blk_xlate_unit #(.N_ENTRIES(4), .INSTR_SIDE(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_upper(wr_upper), .wr_data(wr_data), .ea(ea),
        .priv_super(priv_super), .acc_write(acc_write),
        .hit(hit_i), .hit_idx(idx_i), .pa(pa_i), .attr_w(w_i), .attr_i(c_i),
        .attr_m(m_i), .attr_g(g_i), .access_ok(ok_i));

    blk_xlate_unit #(.N_ENTRIES(4), .INSTR_SIDE(1'b0)) dut_d (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_upper(wr_upper), .wr_data(wr_data), .ea(ea),
        .priv_super(priv_super), .acc_write(acc_write),
        .hit(hit_d), .hit_idx(idx_d), .pa(pa_d), .attr_w(w_d), .attr_i(c_d),
        .attr_m(m_d), .attr_g(g_d), .access_ok(ok_d));

    function automatic logic [31:0] next_rnd(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    // Expected {hit, idx, pa, w, i, m, g, ok} from the shadow registers.
    function automatic logic [39:0] model(input logic [31:0] a, input logic sup,
                                          input logic wrt, input bit instr);
        logic [39:0] r;
        logic [14:0] msk;
        logic [3:0]  at;
        logic        ok;
        logic [31:0] p;
        r = '0;
        for (int e = 3; e >= 0; e--) begin
            msk = {4'b0, up_sh[e][12:2]};
            if ((((a[31:17] ^ up_sh[e][31:17]) & ~msk) == 15'd0) &&
                (sup ? up_sh[e][1] : up_sh[e][0])) begin
                p  = {(lo_sh[e][31:17] & ~msk) | (a[31:17] & msk), a[16:0]};
                at = lo_sh[e][6:3];
                if (instr) at[0] = 1'b0;
                case (lo_sh[e][1:0])
                    2'b00:   ok = 1'b0;
                    2'b10:   ok = 1'b1;
                    default: ok = !wrt;
                endcase
                r = {1'b1, 2'(e), p, at, ok};
            end
        end
        return r;
    endfunction

    task automatic wr(input int e, input logic hi, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 2'(e); wr_upper = hi; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        if (hi) up_sh[e] = d; else lo_sh[e] = d;
    endtask

    task automatic chk(input string tag, input logic [31:0] a,
                       input logic sup, input logic wrt);
        logic [39:0] exp_i, exp_d, got_i, got_d;
        ea = a; priv_super = sup; acc_write = wrt;
        #1;
        exp_i = model(a, sup, wrt, 1'b1);
        exp_d = model(a, sup, wrt, 1'b0);
        got_i = {hit_i, idx_i, pa_i, w_i, c_i, m_i, g_i, ok_i};
        got_d = {hit_d, idx_d, pa_d, w_d, c_d, m_d, g_d, ok_d};
        n_vec++;
        if (got_i !== exp_i || got_d !== exp_d) begin
            n_bad++;
            $display("FAIL %s ea=%h sup=%0d wr=%0d instr got=%h exp=%h data got=%h exp=%h",
                     tag, a, sup, wrt, got_i, exp_i, got_d, exp_d);
        end
        #1;
    endtask

    task automatic chk4(input string tag, input logic [31:0] a);
        for (int s = 0; s < 2; s++)
            for (int w = 0; w < 2; w++)
                chk(tag, a, s[0], w[0]);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] base;
        logic [10:0] len;
        for (int e = 0; e < 4; e++) begin up_sh[e] = '0; lo_sh[e] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: nothing hits straight after reset
        chk4("R1", 32'h0000_0000);
        chk4("R1", 32'hFFFF_FFFF);

        // R2 R3 R5: every block length, inside and at the edges of the block
        for (int n = 0; n <= 11; n++) begin
            len  = 11'((1 << n) - 1);
            base = 32'h5A5A_0000 ^ (32'(n) << 27);
            wr(0, 1'b1, {base[31:17], 4'b0, len, 2'b11});
            wr(0, 1'b0, {15'h2C3F ^ 15'(n), 10'b0, 4'b1010, 1'b0, 2'b10});
            chk4("R2", base | 32'h0001_2345);
            chk4("R5", base ^ 32'h0000_FFFF);
            if (n > 0) chk4("R3", base ^ (32'h1 << (16 + n)));
            if (n < 15) chk4("R3", base ^ (32'h1 << (17 + n)));
        end

        // R4: mode gating, each valid bit alone
        wr(0, 1'b1, {15'h0101, 4'b0, 11'h0, 2'b10});
        chk4("R4", 32'h0202_1000);
        wr(0, 1'b1, {15'h0101, 4'b0, 11'h0, 2'b01});
        chk4("R4", 32'h0202_1000);

        // R6: four overlapping entries, removed one at a time from the bottom
        for (int e = 0; e < 4; e++) begin
            wr(e, 1'b1, {15'h0700, 4'b0, 11'h3FF, 2'b11});
            wr(e, 1'b0, {15'h1000 + 15'(e), 10'b0, 4'(e), 1'b0, 2'(e)});
        end
        for (int e = 0; e < 4; e++) begin
            chk4("R6", 32'h0E00_0040 ^ (32'(e) << 18));
            wr(e, 1'b1, 32'h0);
        end
        chk4("R1", 32'h0E00_0040);

        // R7 R8: every protection code and attribute pattern
        wr(1, 1'b1, {15'h4321, 4'b0, 11'h7, 2'b11});
        for (int pr = 0; pr < 4; pr++)
            for (int at = 0; at < 16; at += 5) begin
                wr(1, 1'b0, {15'h3333, 10'b0, 4'(at), 1'b0, 2'(pr)});
                chk4("R8", 32'h8642_1234);
                chk4("R7", 32'h8652_0000);
            end

        // R9: guarded written as 1 on both instances
        wr(1, 1'b0, {15'h1111, 10'b0, 4'b0001, 1'b0, 2'b10});
        chk4("R9", 32'h8642_0008);

        // R2 R3 R4 R5 R6 R7 R8 R9: pseudo-random registers and addresses
        for (int blk = 0; blk < 40; blk++) begin
            for (int e = 0; e < 4; e++) begin
                rng = next_rnd(rng); wr(e, 1'b1, rng & 32'hFFFE_1FFF);
                rng = next_rnd(rng); wr(e, 1'b0, rng & 32'hFFFE_007B);
            end
            for (int v = 0; v < 50; v++) begin
                logic [31:0] a;
                rng = next_rnd(rng);
                a = rng;
                if (rng[1]) a[31:17] = up_sh[rng[3:2]][31:17] ^
                    (a[31:17] & {4'b0, up_sh[rng[3:2]][12:2]});
                rng = next_rnd(rng);
                chk("R2", a, rng[0], rng[1]);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule